// File: doc/BRIEF.md
# Triple Prescaled Interval Timer

This block holds three interval timers behind a small byte-wide register bus. One free-running divider of the system clock produces two tick strobes. The fast strobe fires once every `FAST_DIV` clocks. The slow strobe fires on every eighth fast strobe. Timers 0 and 1 count slow ticks and timer 2 counts fast ticks.

Each enabled timer counts ticks upward from zero. When the count reaches the timer's 8-bit target, the count drops back to zero and a 4-bit hit counter for that timer steps by one. Software polls the hit counters. A read returns the hit value and empties the counter. The control register enables the timers one by one. The same register can also fire one-cycle clear strobes toward the neighbouring mailbox ports.

Each timer channel is a two-state machine:
- `CH_OFF`: the channel is idle and its count and hits are frozen.
- `CH_RUN`: the channel is counting.
- Arm transition (`CH_OFF` to `CH_RUN`): taken on the first clock that sees the channel's enable bit at 1. In that clock both the internal count and the hit counter are zeroed.
- Drop transition (`CH_RUN` to `CH_OFF`): taken on the first clock that sees the enable bit at 0.

Top module: `ivt_timer3`

## Requirements
- R1: After reset, reads of every register return 0 and `port_clr` is 0.
- R2: The control register is at address 0x0. Bits 0, 1 and 2 enable timers 0, 1 and 2 (1 = on). A read returns the three enable bits in bits 2:0, with bits 7:3 at 0.
- R3: A write to address 0x0 drives `port_clr` for exactly the next cycle. Data bit 4 sets `port_clr[1:0]`, data bit 5 sets `port_clr[3:2]`, and both bits set all four. Otherwise `port_clr` is 0.
- R4: The 8-bit targets of timers 0, 1 and 2 are written and read back at addresses 0x4, 0x5 and 0x6.
- R5: A running timer counts its ticks from 0. On the tick that brings the count to the target T, the count returns to 0 and the hit counter steps by 1. The hit counter therefore advances once per T ticks.
- R6: A target of 0 acts as 256 ticks.
- R7: Fast ticks are consumed on clock edges numbered FAST_DIV·k after reset release. Slow ticks are consumed on edges numbered 8·FAST_DIV·k. Timer 2 uses fast ticks; timers 0 and 1 use slow ticks.
- R8: Reading a hit counter returns its value and clears it. A hit that lands on the read clock is kept, so the counter becomes 1.
- R9: A hit counter wraps from 15 to 0.
- R10: When a control write changes an enable bit from 0 to 1, the timer arms on the next clock: its count and hits become 0 and it counts ticks from the clock after that. A disabled timer holds its hit value, apart from clear-on-read.
- R11: The hit counters of timers 0, 1 and 2 are at addresses 0x8, 0x9 and 0xA. Unmapped addresses read as 0. `rdata` is updated on the clock edge that samples `rd_en` and holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 4 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| port_clr | output | 4 | One-cycle clear strobes for the four mailbox ports |

## Verification
The bench builds the block with `FAST_DIV` = 2. This gives a fast tick every 2 clocks and a slow tick every 16 clocks. With those rates, many hit counter wraps, a full 256-tick period from a zero target, and reads that fall on the same edge as a hit all fit in a few thousand cycles. The bench predicts each hit read by counting the tick edges that fall inside each enable window and dividing by the target.

// File: rtl/ivt_pkg.sv
package ivt_pkg;
    localparam int NUM_TMR   = 3;
    localparam int ADDR_W    = 4;
    localparam int DATA_W    = 8;
    localparam int HIT_W     = 4;
    localparam int NUM_PORTS = 4;
    localparam int CLR_LO_B  = 4;
    localparam int CLR_HI_B  = 5;

    localparam logic [ADDR_W-1:0] A_CTRL = 4'h0;
    localparam logic [ADDR_W-1:0] A_TGT0 = 4'h4;
    localparam logic [ADDR_W-1:0] A_HIT0 = 4'h8;

    typedef enum logic [0:0] {
        CH_OFF = 1'b0,
        CH_RUN = 1'b1
    } ch_state_t;
endpackage

// File: rtl/ivt_divider.sv
module ivt_divider #(
    parameter int FAST_DIV  = 384,
    parameter int SLOW_MULT = 8
) (
    input  logic clk,
    input  logic rst_n,
    output logic fast_tick,
    output logic slow_tick
);
    localparam int DIV_W = (FAST_DIV > 2) ? $clog2(FAST_DIV) : 1;
    localparam int MUL_W = (SLOW_MULT > 2) ? $clog2(SLOW_MULT) : 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(FAST_DIV - 1);
    localparam logic [MUL_W-1:0] MUL_LAST = MUL_W'(SLOW_MULT - 1);

    logic [DIV_W-1:0] div_q;
    logic [MUL_W-1:0] mul_q;

    assign fast_tick = (div_q == DIV_LAST);
    assign slow_tick = fast_tick && (mul_q == MUL_LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
            mul_q <= '0;
        end else if (fast_tick) begin
            div_q <= '0;
            mul_q <= (mul_q == MUL_LAST) ? '0 : mul_q + 1'b1;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end
endmodule

// File: rtl/ivt_channel.sv
module ivt_channel
    import ivt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              tick,
    input  logic [DATA_W-1:0] target,
    input  logic              hit_clr,
    output logic [HIT_W-1:0]  hit
);
    localparam int CMP_W = DATA_W + 1;

    ch_state_t          st_q, st_d;
    logic [DATA_W-1:0]  cnt_q;
    logic [HIT_W-1:0]   hit_q;
    logic [CMP_W-1:0]   cnt_inc;
    logic [CMP_W-1:0]   tgt_eff;
    logic               arm;
    logic               step;
    logic               match;

    assign tgt_eff = (target == '0) ? CMP_W'(1 << DATA_W) : {1'b0, target};
    assign cnt_inc = {1'b0, cnt_q} + 1'b1;
    assign arm     = (st_q == CH_OFF) && en;
    assign step    = (st_q == CH_RUN) && en && tick;
    assign match   = step && (cnt_inc == tgt_eff);
    assign hit     = hit_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            CH_OFF:  st_d = en ? CH_RUN : CH_OFF;
            CH_RUN:  st_d = en ? CH_RUN : CH_OFF;
            default: st_d = CH_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= CH_OFF;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            hit_q <= '0;
        end else if (arm) begin
            cnt_q <= '0;
            hit_q <= '0;
        end else begin
            if (step) cnt_q <= match ? '0 : cnt_inc[DATA_W-1:0];
            if (hit_clr)    hit_q <= match ? HIT_W'(1) : '0;
            else if (match) hit_q <= hit_q + 1'b1;
        end
    end
endmodule

// File: rtl/ivt_regbank.sv
module ivt_regbank
    import ivt_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic                           rd_en,
    input  logic [ADDR_W-1:0]              addr,
    input  logic [DATA_W-1:0]              wdata,
    input  logic [NUM_TMR-1:0][HIT_W-1:0]  hit_all,
    output logic [NUM_TMR-1:0]             en_bits,
    output logic [NUM_TMR-1:0][DATA_W-1:0] tgt_all,
    output logic [NUM_TMR-1:0]             hit_clr,
    output logic [DATA_W-1:0]              rdata,
    output logic [NUM_PORTS-1:0]           port_clr
);
    localparam int HALF = NUM_PORTS / 2;

    logic              ctrl_wr;
    logic [DATA_W-1:0] rd_mux;

    assign ctrl_wr = wr_en && (addr == A_CTRL);

    for (genvar g = 0; g < NUM_TMR; g++) begin : g_tmr
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                tgt_all[g] <= '0;
            else if (wr_en && (addr == A_TGT0 + ADDR_W'(g)))
                tgt_all[g] <= wdata;
        end
        assign hit_clr[g] = rd_en && (addr == A_HIT0 + ADDR_W'(g));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_bits  <= '0;
            port_clr <= '0;
        end else begin
            if (ctrl_wr) en_bits <= wdata[NUM_TMR-1:0];
            port_clr <= ctrl_wr ? {{HALF{wdata[CLR_HI_B]}}, {HALF{wdata[CLR_LO_B]}}} : '0;
        end
    end

    always_comb begin
        rd_mux = '0;
        if (addr == A_CTRL) rd_mux = DATA_W'(en_bits);
        for (int i = 0; i < NUM_TMR; i++) begin
            if (addr == A_TGT0 + ADDR_W'(i)) rd_mux = tgt_all[i];
            if (addr == A_HIT0 + ADDR_W'(i)) rd_mux = DATA_W'(hit_all[i]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     rdata <= '0;
        else if (rd_en) rdata <= rd_mux;
    end
endmodule

// File: rtl/ivt_timer3.sv
module ivt_timer3
    import ivt_pkg::*;
#(
    parameter int FAST_DIV  = 384,
    parameter int SLOW_MULT = 8,
    parameter int FAST_IDX  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [NUM_PORTS-1:0] port_clr
);
    logic                           fast_tick;
    logic                           slow_tick;
    logic [NUM_TMR-1:0]             en_bits;
    logic [NUM_TMR-1:0]             hit_clr;
    logic [NUM_TMR-1:0][DATA_W-1:0] tgt_all;
    logic [NUM_TMR-1:0][HIT_W-1:0]  hit_all;

    ivt_divider #(
        .FAST_DIV  (FAST_DIV),
        .SLOW_MULT (SLOW_MULT)
    ) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .fast_tick (fast_tick),
        .slow_tick (slow_tick)
    );

    ivt_regbank u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .addr     (addr),
        .wdata    (wdata),
        .hit_all  (hit_all),
        .en_bits  (en_bits),
        .tgt_all  (tgt_all),
        .hit_clr  (hit_clr),
        .rdata    (rdata),
        .port_clr (port_clr)
    );

    for (genvar g = 0; g < NUM_TMR; g++) begin : g_ch
        logic ch_tick;
        if (g == FAST_IDX) begin : g_fast
            assign ch_tick = fast_tick;
        end else begin : g_slow
            assign ch_tick = slow_tick;
        end
        ivt_channel u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .en      (en_bits[g]),
            .tick    (ch_tick),
            .target  (tgt_all[g]),
            .hit_clr (hit_clr[g]),
            .hit     (hit_all[g])
        );
    end
endmodule

// File: rtl/ivt_checker.sv
module ivt_checker
    import ivt_pkg::*;
(
    input logic                          clk,
    input logic                          rst_n,
    input logic                          wr_en,
    input logic                          rd_en,
    input logic [ADDR_W-1:0]             addr,
    input logic [DATA_W-1:0]             rdata,
    input logic [NUM_PORTS-1:0]          port_clr,
    input logic                          fast_tick,
    input logic                          slow_tick,
    input logic [NUM_TMR-1:0]            en_bits,
    input logic [NUM_TMR-1:0][HIT_W-1:0] hit_all
);
    AST_SLOW_INSIDE_FAST: assert property (@(posedge clk) disable iff (!rst_n)
        slow_tick |-> fast_tick); // R7

    AST_CLR_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (|port_clr) |-> $past(wr_en && (addr == A_CTRL))); // R3

    AST_CLR_PAIRED: assert property (@(posedge clk) disable iff (!rst_n)
        (port_clr[0] == port_clr[1]) && (port_clr[2] == port_clr[3])); // R3

    AST_CTRL_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rd_en && (addr == A_CTRL)) |-> (rdata == DATA_W'($past(en_bits)))); // R2

    for (genvar g = 0; g < NUM_TMR; g++) begin : g_chk
        AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rd_en && (addr == A_HIT0 + ADDR_W'(g))) |-> (hit_all[g] <= HIT_W'(1))); // R8

        AST_OFF_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
            $past(!en_bits[g] && !(rd_en && (addr == A_HIT0 + ADDR_W'(g))))
            |-> $stable(hit_all[g])); // R10

        AST_HIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
            (hit_all[g] == $past(hit_all[g])) ||
            (hit_all[g] == HIT_W'($past(hit_all[g]) + 1'b1)) ||
            (hit_all[g] <= HIT_W'(1))); // R9
    end
endmodule

bind ivt_timer3 ivt_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .addr      (addr),
    .rdata     (rdata),
    .port_clr  (port_clr),
    .fast_tick (fast_tick),
    .slow_tick (slow_tick),
    .en_bits   (en_bits),
    .hit_all   (hit_all)
);

// File: tb/test_ivt_timer3.sv
module test_ivt_timer3;
    localparam int FDIV = 2;
    localparam int BIG  = 1 << 30;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [3:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic [3:0] port_clr;

    int total = 0;
    int bad = 0;
    bit done = 0;
    int ecnt = 0;
    logic mon_rd = 1'b0;

    int exp_q[$];
    string tag_q[$];

    int en_e[3], dis_e[3], lrd[3], tgt[3];
    bit en_now[3];
    int ctrl_bits = 0;

    ivt_timer3 #(.FAST_DIV(FDIV)) i_ivt_timer3 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .port_clr(port_clr)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) ecnt <= 0;
        else        ecnt <= ecnt + 1;
    end

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Ticks a timer has consumed on edges up to x (R5, R7, R10).
    function automatic int ticks_upto(input int i, input int x);
        int lo, hi, d;
        lo = en_e[i] + 2;
        hi = (x < dis_e[i]) ? x : dis_e[i];
        if (hi < lo) return 0;
        d = (i == 2) ? FDIV : 8 * FDIV;
        return hi / d - (lo - 1) / d;
    endfunction

    always @(posedge clk) mon_rd <= rd_en;

    always @(negedge clk) begin
        if (mon_rd) begin
            if (exp_q.size() == 0) chk("R11 unexpected read", 1, 0);
            else chk(tag_q.pop_front(), int'(rdata), exp_q.pop_front());
        end
    end

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        int w;
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk); #1;
        w = ecnt;
        if (a == 4'h0) begin
            ctrl_bits = int'(d[2:0]);
            for (int i = 0; i < 3; i++) begin
                if (d[i] && !en_now[i]) begin
                    en_e[i] = w; lrd[i] = w + 1; dis_e[i] = BIG;
                end else if (!d[i] && en_now[i]) begin
                    dis_e[i] = w;
                end
                en_now[i] = d[i];
            end
        end else if (a >= 4'h4 && a <= 4'h6) begin
            tgt[a - 4'h4] = int'(d);
        end
        @(negedge clk);
        chk("R3 port_clr after write", int'(port_clr),
            (a == 4'h0) ? int'({d[5], d[5], d[4], d[4]}) : 0);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, input string tag);
        int r, e, tt, i;
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(posedge clk); #1;
        r = ecnt;
        e = 0;
        if (a == 4'h0) e = ctrl_bits;
        else if (a >= 4'h4 && a <= 4'h6) e = tgt[a - 4'h4];
        else if (a >= 4'h8 && a <= 4'hA) begin
            i = int'(a) - 8;
            tt = (tgt[i] == 0) ? 256 : tgt[i];
            e = ((ticks_upto(i, r - 1) / tt) - (ticks_upto(i, lrd[i] - 1) / tt)) & 15;
            lrd[i] = r;
        end
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (400000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=expired expected=finished");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 3; i++) begin
            en_e[i] = -10; dis_e[i] = -10; lrd[i] = 0; tgt[i] = 0; en_now[i] = 0;
        end
        repeat (3) @(negedge clk);
        chk("R1 port_clr in reset", int'(port_clr), 0);
        chk("R1 rdata in reset", int'(rdata), 0);
        rst_n = 1'b1;

        // R1, R11: reset values and unmapped addresses
        rd(4'h0, "R1 ctrl");
        for (int i = 0; i < 3; i++) rd(4'h4 + 4'(i), "R1 target");
        for (int i = 0; i < 3; i++) rd(4'h8 + 4'(i), "R1 hits");
        rd(4'hF, "R11 unmapped 0xF");
        rd(4'h3, "R11 unmapped 0x3");

        // R4: targets
        wr(4'h4, 8'd3);
        wr(4'h5, 8'd2);
        wr(4'h6, 8'd5);
        rd(4'h4, "R4 target0");
        rd(4'h5, "R4 target1");
        rd(4'h6, "R4 target2");

        // R2: enables and readback
        wr(4'h0, 8'h07);
        rd(4'h0, "R2 ctrl readback");

        // R5, R7, R8, R9: periodic reads at varied offsets
        for (int k = 0; k < 8; k++) begin
            idle(37 + 13 * k);
            rd(4'h8, "R5 R7 hit0 slow");
            rd(4'h9, "R5 R7 hit1 slow");
            rd(4'hA, "R5 R8 R9 hit2 fast");
        end
        for (int k = 0; k < 12; k++) begin
            idle(k);
            rd(4'hA, "R8 back-to-back hit2");
        end

        // R3: mailbox port clear strobes
        wr(4'h0, 8'h17);
        wr(4'h0, 8'h27);
        wr(4'h0, 8'h37);
        @(negedge clk);
        chk("R3 strobe lasts one cycle", int'(port_clr), 0);
        rd(4'h0, "R2 ctrl unchanged by clear bits");

        // R10: disabled timer holds its hits
        wr(4'h0, 8'h06);
        idle(90);
        rd(4'h8, "R10 hit0 after disable");
        idle(60);
        rd(4'h8, "R10 hit0 frozen");

        // R9: target 1 on the fast timer, wrap
        wr(4'h0, 8'h02);
        wr(4'h6, 8'd1);
        wr(4'h0, 8'h06);
        idle(41);
        rd(4'hA, "R9 wrap target1");
        idle(20);
        rd(4'hA, "R9 wrap target1 second");

        // R6: target 0 acts as 256
        wr(4'h0, 8'h02);
        wr(4'h6, 8'd0);
        wr(4'h0, 8'h06);
        idle(300);
        rd(4'hA, "R6 before first 256");
        idle(800);
        rd(4'hA, "R6 target0 as 256");

        // R10: re-enable clears count and hits
        idle(70);
        wr(4'h0, 8'h04);
        wr(4'h0, 8'h06);
        idle(50);
        rd(4'h9, "R10 hit1 after re-arm");
        idle(33);
        rd(4'h9, "R10 hit1 later");

        idle(4);
        chk("R11 no pending reads", exp_q.size(), 0);
        finish_run();
    end
endmodule